// File: doc/BRIEF.md
# Cyclic Sync Pulse Generator

The block drives two timed output pulses from a free-running 64-bit system time expressed in nanoseconds. Software first programs an absolute start time, a primary period, a secondary delay and a pulse width, and then arms the unit. The primary pulse (SYNC0) fires when the system time reaches the programmed time, and then once per period after that. The secondary pulse (SYNC1) follows each primary pulse after the programmed delay. A primary period of zero gives exactly one pulse on each output.

The pulse width is counted in 10 ns units. With the default 5 ns clock, one unit is two clock cycles. A width of zero selects acknowledge mode. In that mode a pulse stays high until the local side reads that channel's status word. While the unit is running, reading the start-time words returns the time of the next primary pulse. A second pair of words returns the time of the next secondary pulse. When mapping is enabled, both pulse states are also copied onto a two-bit event output.

Top module: `cyclic_sync_gen`

Register words are 32 bits wide and are selected by `regAddr`:

| Address | Contents |
|---|---|
| 0 | Control: bit 0 unit run, bit 1 SYNC0 enable, bit 2 SYNC1 enable, bit 8 event mapping |
| 1, 2 | Start time, low and high word. A read returns the next SYNC0 time |
| 3 | SYNC0 period |
| 4 | SYNC1 delay |
| 5 | Pulse width, bits 15:0 |
| 6 | Activation status: bit 0 first SYNC0 pending, bit 1 first SYNC1 pending |
| 7 | SYNC0 state in bit 0 |
| 8 | SYNC1 state in bit 0 |
| 9, 10 | Next SYNC1 time, low and high word |

All other addresses read as zero. All registers and outputs reset to zero.

## Requirements
- R1: While control bit 0 is clear, no pulse is produced, even when the system time passes the programmed start time. Writes to addresses 1 and 2 store the start time only while bit 0 is clear. Reading those addresses returns the stored value.
- R2: After arming (control bit 0 written from 0 to 1), SYNC0 rises on the first clock edge at which the system time is greater than or equal to the next SYNC0 time. Each such event then advances the next SYNC0 time, read at addresses 1 and 2, by the period at address 3.
- R3: A period of 0 produces exactly one SYNC0 event and one SYNC1 event after arming.
- R4: The first SYNC1 time is the start time plus the delay at address 4. Each SYNC1 event then advances the next SYNC1 time, read at addresses 9 and 10, by the SYNC0 period.
- R5: Control bits 1 and 2 each gate their own output. A disabled channel keeps advancing its timing but stays low.
- R6: With a width N other than zero, a pulse stays high for 2·N clock cycles.
- R7: With a width of zero, a pulse stays high until its status word (address 7 or 8) is read, and falls on the edge after that read. Reads of other addresses have no effect on it.
- R8: Arming sets activation status bits 0 and 1 to the SYNC0 and SYNC1 enables being written. Each bit clears when its channel's first event occurs.
- R9: Writing control bit 0 as 0 while the unit is running forces both outputs low, and clears the status bits, on that same clock edge.
- R10: `evtSync[0]` follows SYNC0 and `evtSync[1]` follows SYNC1 while control bit 8 is set. Both are 0 while bit 8 is clear.
- R11: After reset, every output and every readable register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 5 ns default period |
| rstN | input | 1 | Active-low synchronous reset |
| sysTime | input | 64 | System time in ns |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe, used for read-to-clear |
| regAddr | input | 4 | Register word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from regAddr |
| sync0Out | output | 1 | SYNC0 pulse |
| sync1Out | output | 1 | SYNC1 pulse |
| evtSync | output | 2 | Pulse states mapped to event bits |

## Verification
The assertions assume that the system time only moves forward. They also assume that the next-pulse times never wrap past 2^64. The stimulus guarantees both: the bench advances the time by 5 ns on every clock and uses start values far below the wrap point. The acknowledge-hold check assumes that the width register is not rewritten while a pulse is high. The bench changes the width only while the unit is stopped.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;
  localparam int REG_AW = 4;
  localparam int DATA_W = 32;
  localparam int N_CH = 2;

  localparam logic [REG_AW-1:0] A_CTRL     = 4'd0;
  localparam logic [REG_AW-1:0] A_START_LO = 4'd1;
  localparam logic [REG_AW-1:0] A_START_HI = 4'd2;
  localparam logic [REG_AW-1:0] A_CYC0     = 4'd3;
  localparam logic [REG_AW-1:0] A_CYC1     = 4'd4;
  localparam logic [REG_AW-1:0] A_LEN      = 4'd5;
  localparam logic [REG_AW-1:0] A_ACT      = 4'd6;
  localparam logic [REG_AW-1:0] A_STAT0    = 4'd7;
  localparam logic [REG_AW-1:0] A_STAT1    = 4'd8;
  localparam logic [REG_AW-1:0] A_NEXT1_LO = 4'd9;
  localparam logic [REG_AW-1:0] A_NEXT1_HI = 4'd10;

  localparam int BIT_RUN = 0;
  localparam int BIT_MAP = 8;

  // Strobes that the register side sends to the timing datapath.
  typedef struct packed {
    logic            arm;
    logic            stop;
    logic [N_CH-1:0] armChan;
    logic            wrLo;
    logic            wrHi;
    logic [N_CH-1:0] ack;
  } syncStrobe_t;
endpackage

// File: rtl/sync_pulse_shaper.sv
module sync_pulse_shaper #(
  parameter int LEN_W = 16,
  parameter int TICKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             kill,
  input  logic             fire,
  input  logic             ack,
  input  logic [LEN_W-1:0] pulseLen,
  output logic             pulseOut
);
  localparam int CNT_W = LEN_W + $clog2(TICKS) + 1;
  localparam logic [CNT_W-1:0] TICKS_C = CNT_W'(TICKS);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] loadVal;
  logic             ackMode;

  assign loadVal = CNT_W'(pulseLen) * TICKS_C - CNT_W'(1);
  assign ackMode = (pulseLen == '0);

  always_ff @(posedge clk) begin
    if (!rstN || kill) begin
      pulseOut <= 1'b0;
      cntQ     <= '0;
    end else if (fire) begin
      pulseOut <= 1'b1;
      cntQ     <= loadVal;
    end else if (pulseOut) begin
      if (ackMode) begin
        if (ack) pulseOut <= 1'b0;
      end else if (cntQ == '0) begin
        pulseOut <= 1'b0;
      end else begin
        cntQ <= cntQ - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sync_regs.sv
module sync_regs
  import sync_gen_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int CYC_W  = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [TIME_W-1:0] nextT0,
  input  logic [TIME_W-1:0] nextT1,
  input  logic [N_CH-1:0]   pend,
  input  logic [N_CH-1:0]   pulse,
  output logic [DATA_W-1:0] regRdData,
  output syncStrobe_t       strb,
  output logic              unitEn,
  output logic [N_CH-1:0]   chanEn,
  output logic              mapEn,
  output logic [CYC_W-1:0]  cycle0,
  output logic [CYC_W-1:0]  cycle1,
  output logic [LEN_W-1:0]  pulseLen
);
  logic ctrlWr;
  assign ctrlWr = regWrEn && (regAddr == A_CTRL);

  always_comb begin
    strb.arm     = ctrlWr && regWrData[BIT_RUN] && !unitEn;
    strb.stop    = ctrlWr && !regWrData[BIT_RUN] && unitEn;
    strb.armChan = regWrData[N_CH:1];
    strb.wrLo    = regWrEn && (regAddr == A_START_LO) && !unitEn;
    strb.wrHi    = regWrEn && (regAddr == A_START_HI) && !unitEn;
    strb.ack[0]  = regRdEn && (regAddr == A_STAT0);
    strb.ack[1]  = regRdEn && (regAddr == A_STAT1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unitEn   <= 1'b0;
      chanEn   <= '0;
      mapEn    <= 1'b0;
      cycle0   <= '0;
      cycle1   <= '0;
      pulseLen <= '0;
    end else if (regWrEn) begin
      unique case (regAddr)
        A_CTRL: begin
          unitEn <= regWrData[BIT_RUN];
          chanEn <= regWrData[N_CH:1];
          mapEn  <= regWrData[BIT_MAP];
        end
        A_CYC0:  cycle0   <= regWrData[CYC_W-1:0];
        A_CYC1:  cycle1   <= regWrData[CYC_W-1:0];
        A_LEN:   pulseLen <= regWrData[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      A_CTRL: begin
        regRdData[BIT_RUN]  = unitEn;
        regRdData[N_CH:1]   = chanEn;
        regRdData[BIT_MAP]  = mapEn;
      end
      A_START_LO: regRdData = nextT0[DATA_W-1:0];
      A_START_HI: regRdData = nextT0[TIME_W-1:DATA_W];
      A_CYC0:     regRdData = DATA_W'(cycle0);
      A_CYC1:     regRdData = DATA_W'(cycle1);
      A_LEN:      regRdData = DATA_W'(pulseLen);
      A_ACT:      regRdData = DATA_W'(pend);
      A_STAT0:    regRdData = DATA_W'(pulse[0]);
      A_STAT1:    regRdData = DATA_W'(pulse[1]);
      A_NEXT1_LO: regRdData = nextT1[DATA_W-1:0];
      A_NEXT1_HI: regRdData = nextT1[TIME_W-1:DATA_W];
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/sync_timebase.sv
module sync_timebase
  import sync_gen_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int CYC_W  = 32,
  parameter int LEN_W  = 16,
  parameter int TICKS  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] sysTime,
  input  syncStrobe_t       strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              unitEn,
  input  logic [N_CH-1:0]   chanEn,
  input  logic [CYC_W-1:0]  cycle0,
  input  logic [CYC_W-1:0]  cycle1,
  input  logic [LEN_W-1:0]  pulseLen,
  output logic [TIME_W-1:0] nextT0,
  output logic [TIME_W-1:0] nextT1,
  output logic [N_CH-1:0]   pend,
  output logic [N_CH-1:0]   pulse
);
  logic [TIME_W-1:0] nextQ [N_CH];
  logic [N_CH-1:0]   doneQ;
  logic [N_CH-1:0]   fire;
  logic              kill;
  logic              oneShot;
  logic [TIME_W-1:0] step;

  assign kill    = strb.stop || !unitEn;
  assign oneShot = (cycle0 == '0);
  assign step    = TIME_W'(cycle0);
  assign nextT0  = nextQ[0];
  assign nextT1  = nextQ[1];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign fire[c] = unitEn && !doneQ[c] && (sysTime >= nextQ[c]) && !strb.stop;

    sync_pulse_shaper #(
      .LEN_W(LEN_W),
      .TICKS(TICKS)
    ) i_shaper (
      .clk     (clk),
      .rstN    (rstN),
      .kill    (kill),
      .fire    (fire[c] && chanEn[c]),
      .ack     (strb.ack[c]),
      .pulseLen(pulseLen),
      .pulseOut(pulse[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < N_CH; c++) nextQ[c] <= '0;
      doneQ <= '0;
      pend  <= '0;
    end else if (strb.arm) begin
      nextQ[1] <= nextQ[0] + TIME_W'(cycle1);
      doneQ    <= '0;
      pend     <= strb.armChan;
    end else if (kill) begin
      doneQ <= '0;
      pend  <= '0;
      if (strb.wrLo) nextQ[0][DATA_W-1:0]      <= wrData;
      if (strb.wrHi) nextQ[0][TIME_W-1:DATA_W] <= wrData;
    end else begin
      for (int c = 0; c < N_CH; c++) begin
        if (fire[c]) begin
          pend[c] <= 1'b0;
          if (oneShot) doneQ[c] <= 1'b1;
          else         nextQ[c] <= nextQ[c] + step;
        end
      end
    end
  end
endmodule

// File: rtl/cyclic_sync_gen.sv
module cyclic_sync_gen
  import sync_gen_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int CYC_W  = 32,
  parameter int LEN_W  = 16,
  parameter int TICKS  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] sysTime,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              sync0Out,
  output logic              sync1Out,
  output logic [N_CH-1:0]   evtSync
);
  syncStrobe_t       strb;
  logic              unitEn;
  logic              mapEn;
  logic [N_CH-1:0]   chanEn;
  logic [N_CH-1:0]   pend;
  logic [N_CH-1:0]   pulse;
  logic [CYC_W-1:0]  cycle0;
  logic [CYC_W-1:0]  cycle1;
  logic [LEN_W-1:0]  pulseLen;
  logic [TIME_W-1:0] nextT0;
  logic [TIME_W-1:0] nextT1;

  sync_regs #(.TIME_W(TIME_W), .CYC_W(CYC_W), .LEN_W(LEN_W)) i_regs (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .nextT0   (nextT0),
    .nextT1   (nextT1),
    .pend     (pend),
    .pulse    (pulse),
    .regRdData(regRdData),
    .strb     (strb),
    .unitEn   (unitEn),
    .chanEn   (chanEn),
    .mapEn    (mapEn),
    .cycle0   (cycle0),
    .cycle1   (cycle1),
    .pulseLen (pulseLen)
  );

  sync_timebase #(.TIME_W(TIME_W), .CYC_W(CYC_W), .LEN_W(LEN_W), .TICKS(TICKS)) i_time (
    .clk     (clk),
    .rstN    (rstN),
    .sysTime (sysTime),
    .strb    (strb),
    .wrData  (regWrData),
    .unitEn  (unitEn),
    .chanEn  (chanEn),
    .cycle0  (cycle0),
    .cycle1  (cycle1),
    .pulseLen(pulseLen),
    .nextT0  (nextT0),
    .nextT1  (nextT1),
    .pend    (pend),
    .pulse   (pulse)
  );

  assign sync0Out = pulse[0];
  assign sync1Out = pulse[1];
  assign evtSync  = pulse & {N_CH{mapEn}};
endmodule

// File: rtl/sync_gen_checker.sv
module sync_gen_checker
  import sync_gen_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic              runBit,
  input logic              unitEn,
  input logic [N_CH-1:0]   chanEn,
  input logic [N_CH-1:0]   pend,
  input logic [TIME_W-1:0] nextT0,
  input logic [LEN_W-1:0]  pulseLen,
  input logic              ack0,
  input logic              sync0Out,
  input logic              sync1Out
);
  logic stopWr;
  assign stopWr = regWrEn && (regAddr == A_CTRL) && !runBit;

  // R1: idle unit keeps both outputs low
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !unitEn |-> (!sync0Out && !sync1Out));

  // R2: next SYNC0 time never moves backwards while running
  a_r2_next_forward: assert property (@(posedge clk) disable iff (!rstN)
    (unitEn && $past(unitEn)) |-> (nextT0 >= $past(nextT0)));

  // R5: a rising pulse needs its channel enable
  a_r5_sync0_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sync0Out) |-> $past(chanEn[0]));
  a_r5_sync1_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sync1Out) |-> $past(chanEn[1]));

  // R7: acknowledge-mode pulse holds until its status read
  a_r7_ack_hold: assert property (@(posedge clk) disable iff (!rstN)
    (sync0Out && pulseLen == '0 && !ack0 && !stopWr && !regWrEn) |=> sync0Out);

  // R8: no pending flag while the unit is idle
  a_r8_pend_idle: assert property (@(posedge clk) disable iff (!rstN)
    !unitEn |-> (pend == '0));

  // R9: a stop write drops outputs and pending flags on the next edge
  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> (!sync0Out && !sync1Out && pend == '0));
endmodule

bind cyclic_sync_gen sync_gen_checker #(.TIME_W(TIME_W), .LEN_W(LEN_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regWrEn (regWrEn),
  .regAddr (regAddr),
  .runBit  (regWrData[0]),
  .unitEn  (unitEn),
  .chanEn  (chanEn),
  .pend    (pend),
  .nextT0  (nextT0),
  .pulseLen(pulseLen),
  .ack0    (strb.ack[0]),
  .sync0Out(sync0Out),
  .sync1Out(sync1Out)
);

// File: tb/test_cyclic_sync_gen.sv
`timescale 1ns/1ps
module test_cyclic_sync_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] sysTime = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        sync0Out;
  logic        sync1Out;
  logic [1:0]  evtSync;

  int nChecks = 0;
  int nErr = 0;
  int cycles = 0;

  cyclic_sync_gen i_cyclic_sync_gen (
    .clk(clk), .rstN(rstN), .sysTime(sysTime), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .sync0Out(sync0Out), .sync1Out(sync1Out), .evtSync(evtSync)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) sysTime <= sysTime + 64'd5;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  logic [63:0] mNext [2];
  bit          mDone [2];
  bit          mPend [2];
  bit          mEn   [2];
  bit          mOut  [2];
  int          mCnt  [2];
  bit          mUnit, mMap;
  logic [31:0] mCyc0, mCyc1;
  int          mLen;

  function automatic logic [31:0] eRead(logic [3:0] a);
    case (a)
      4'd0:  return {23'd0, mMap, 5'd0, mEn[1], mEn[0], mUnit};
      4'd1:  return mNext[0][31:0];
      4'd2:  return mNext[0][63:32];
      4'd3:  return mCyc0;
      4'd4:  return mCyc1;
      4'd5:  return 32'(mLen);
      4'd6:  return {30'd0, mPend[1], mPend[0]};
      4'd7:  return {31'd0, mOut[0]};
      4'd8:  return {31'd0, mOut[1]};
      4'd9:  return mNext[1][31:0];
      4'd10: return mNext[1][63:32];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit st, ar;
    bit f [2];
    bit ak [2];
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin
        mNext[i] = '0; mDone[i] = 0; mPend[i] = 0; mEn[i] = 0; mOut[i] = 0; mCnt[i] = 0;
      end
      mUnit = 0; mMap = 0; mCyc0 = '0; mCyc1 = '0; mLen = 0;
    end else begin
      st = regWrEn && regAddr == 4'd0 && !regWrData[0] && mUnit;
      ar = regWrEn && regAddr == 4'd0 && regWrData[0] && !mUnit;
      for (int i = 0; i < 2; i++) begin
        f[i]  = mUnit && !mDone[i] && (sysTime >= mNext[i]) && !st;
        ak[i] = regRdEn && regAddr == 4'(7 + i);
      end
      for (int i = 0; i < 2; i++) begin
        if (st || !mUnit) begin
          mOut[i] = 0; mCnt[i] = 0;
        end else if (f[i] && mEn[i]) begin
          mOut[i] = 1; mCnt[i] = mLen * 2 - 1;
        end else if (mOut[i]) begin
          if (mLen == 0) begin
            if (ak[i]) mOut[i] = 0;
          end else if (mCnt[i] == 0) mOut[i] = 0;
          else mCnt[i]--;
        end
      end
      if (ar) begin
        mNext[1] = mNext[0] + 64'(mCyc1);
        mDone[0] = 0; mDone[1] = 0;
        mPend[0] = regWrData[1]; mPend[1] = regWrData[2];
      end else if (!mUnit || st) begin
        mDone[0] = 0; mDone[1] = 0; mPend[0] = 0; mPend[1] = 0;
        if (!mUnit && regWrEn && regAddr == 4'd1) mNext[0][31:0] = regWrData;
        if (!mUnit && regWrEn && regAddr == 4'd2) mNext[0][63:32] = regWrData;
      end else begin
        for (int i = 0; i < 2; i++) if (f[i]) begin
          mPend[i] = 0;
          if (mCyc0 == 0) mDone[i] = 1;
          else mNext[i] = mNext[i] + 64'(mCyc0);
        end
      end
      if (regWrEn) case (regAddr)
        4'd0: begin mUnit = regWrData[0]; mEn[0] = regWrData[1]; mEn[1] = regWrData[2]; mMap = regWrData[8]; end
        4'd3: mCyc0 = regWrData;
        4'd4: mCyc1 = regWrData;
        4'd5: mLen = int'(regWrData[15:0]);
        default: ;
      endcase
    end
    #1;
    check("R2 sync0 vs model", 64'(sync0Out), 64'(mOut[0]));
    check("R4 sync1 vs model", 64'(sync1Out), 64'(mOut[1]));
    check("R10 events vs model", 64'(evtSync), 64'({mOut[1] & mMap, mOut[0] & mMap}));
  end

  task automatic wrReg(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [3:0] a, string req, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1;
    d = regRdData;
    check(req, 64'(d), 64'(eRead(a)));
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic countRises(int n, output int r0, output int r1);
    bit p0, p1;
    r0 = 0; r1 = 0; p0 = sync0Out; p1 = sync1Out;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (sync0Out && !p0) r0++;
      if (sync1Out && !p1) r1++;
      p0 = sync0Out; p1 = sync1Out;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      nErr++;
      $display("FAIL watchdog: actual %0d expected below 50000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] s;
    int r0, r1, w;
    repeat (8) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11 sync0 reset", 64'(sync0Out), 64'd0);
    check("R11 sync1 reset", 64'(sync1Out), 64'd0);
    rdReg(4'd0, "R11 ctrl reset", d);
    check("R11 ctrl value", 64'(d), 64'd0);
    rdReg(4'd5, "R11 len reset", d);
    check("R11 len value", 64'(d), 64'd0);

    wrReg(4'd3, 32'd200);
    wrReg(4'd4, 32'd60);
    wrReg(4'd5, 32'd3);
    wrReg(4'd1, 32'd1000);
    wrReg(4'd2, 32'd0);
    rdReg(4'd1, "R1 start readback", d);
    check("R1 start value", 64'(d), 64'd1000);
    // R1: idle unit ignores a start time already reached
    countRises(260, r0, r1);
    check("R1 no pulse while idle", 64'(r0 + r1), 64'd0);

    s = sysTime + 64'd400;
    wrReg(4'd1, s[31:0]);
    wrReg(4'd0, 32'h107);
    rdReg(4'd6, "R8 pending after arm", d);
    check("R8 pending both", 64'(d), 64'd3);
    wait (sync0Out);
    @(negedge clk);
    w = 0;
    while (sync0Out) begin w++; @(negedge clk); end
    check("R6 width 3 units", 64'(w), 64'd6);
    rdReg(4'd6, "R8 pending after sync0", d);
    check("R8 sync1 still pending", 64'(d), 64'd2);
    rdReg(4'd1, "R2 next sync0 readback", d);
    check("R2 next sync0 time", 64'(d), 64'(s[31:0] + 32'd200));
    wait (sync1Out);
    @(negedge clk);
    check("R10 evt1 mapped", 64'(evtSync[1]), 64'd1);
    rdReg(4'd9, "R4 next sync1 readback", d);
    check("R4 next sync1 time", 64'(d), 64'(s[31:0] + 32'd260));
    // R1: start write while running is ignored
    wrReg(4'd1, 32'd5);
    rdReg(4'd1, "R1 start write ignored", d);
    check("R1 not overwritten", 64'(d == 32'd5), 64'd0);

    // R5: SYNC1 disabled, SYNC0 continues
    wrReg(4'd0, 32'h103);
    countRises(120, r0, r1);
    check("R5 sync1 silent", 64'(r1), 64'd0);
    check("R5 sync0 continues", 64'(r0 >= 2), 64'd1);

    // R9: stop during a pulse
    wait (sync0Out);
    wrReg(4'd0, 32'h0);
    check("R9 sync0 forced low", 64'(sync0Out), 64'd0);
    rdReg(4'd6, "R9 pending cleared", d);
    check("R9 pending value", 64'(d), 64'd0);

    // R3: single shot
    wrReg(4'd3, 32'd0);
    wrReg(4'd5, 32'd2);
    s = sysTime + 64'd300;
    wrReg(4'd1, s[31:0]);
    wrReg(4'd0, 32'h107);
    countRises(250, r0, r1);
    check("R3 one sync0 pulse", 64'(r0), 64'd1);
    check("R3 one sync1 pulse", 64'(r1), 64'd1);
    wrReg(4'd0, 32'h0);

    // R7: acknowledge mode, mapping off
    wrReg(4'd5, 32'd0);
    wrReg(4'd3, 32'd2000);
    s = sysTime + 64'd100;
    wrReg(4'd1, s[31:0]);
    wrReg(4'd0, 32'h003);
    wait (sync0Out);
    repeat (40) @(negedge clk);
    check("R7 held in ack mode", 64'(sync0Out), 64'd1);
    check("R10 events off when unmapped", 64'(evtSync), 64'd0);
    rdReg(4'd0, "R7 other read", d);
    check("R7 other read no clear", 64'(sync0Out), 64'd1);
    rdReg(4'd7, "R7 status read", d);
    check("R7 status shows high", 64'(d), 64'd1);
    check("R7 cleared after read", 64'(sync0Out), 64'd0);
    wrReg(4'd0, 32'h0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule